// File: doc/BRIEF.md
# Training-Word Bit-Slip Aligner

This block recovers byte boundaries from a serial bit stream that carries no framing signal and no start bits. One bit arrives on every clock. After reset the far end repeats a fixed 8-bit training word. The block collects the incoming bits into words and compares each word with the training pattern. When a word does not match, the block shifts its word boundary one bit later and tries again. It does this until the boundary lines up with the pattern.

A single matching word is not enough to trust the alignment. The block waits until several matching words arrive in a row, then declares the link up and freezes the boundary. From then on, every received word is presented on the parallel output with a single-cycle valid strobe. A status output shows how many slips have been taken. A sticky flag shows when the search has gone round every possible bit offset without success.

Top module: `bitslip_aligner`

## Requirements
- R1: While `rst` is high and after it is released, `linkUp`, `wordValid`, `rotated` and `slipCount` are all zero. A reset during lock drops the link and restarts the search.
- R2: Bits are packed most significant bit first, and the first received bit of a word lands in `wordOut[7]`. The training word is 8'hF0. Each slip delays the word boundary by exactly one bit and raises `slipCount` by one. If the stream is the training word advanced by p bits, lock is reached with `slipCount` equal to (8 - p) mod 8.
- R3: After a slip, the next two completed words are ignored. In a stream that never matches, successive changes of `slipCount` are therefore exactly 25 cycles apart (three word periods plus the one held bit).
- R4: The link is declared only after 4 consecutive matching words. Three matches followed by a mismatch cause a slip and no lock. Four matches lock with no slip taken.
- R5: Once `linkUp` rises, it stays high until reset.
- R6: After 8 slips without a lock, `slipCount` wraps to 0 and the search continues. `rotated` goes high at that wrap and stays high until reset.
- R7: While locked, `slipCount` is frozen and the boundary does not move. Every later word, training or not, appears on `wordOut` with `wordValid` high for one cycle. `wordValid` is never high without `linkUp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serIn | input | 1 | Serial data input |
| wordOut | output | 8 | Most recently assembled word, first bit in the MSB |
| wordValid | output | 1 | One-cycle strobe marking a new word while locked |
| linkUp | output | 1 | Alignment found and boundary frozen |
| slipCount | output | 3 | Number of slips taken, modulo 8 |
| rotated | output | 1 | Sticky: the search has wrapped through all offsets |

## Verification
Training streams are started at each of the eight bit offsets. This separates a correct one-bit slip, which gives exactly (8 - p) mod 8 slips, from slips of the wrong size or direction. An all-zero stream never matches, so it shows the spacing set by the settle window, the count wrap and the sticky rotation flag. Streams with exactly three and exactly four training words followed by zeros mark the lock threshold. After lock, a run of arbitrary data bytes is compared word for word against the transmitted bytes. This shows that the boundary stays frozen and that each word is strobed once.

// File: rtl/bitslip_aligner_pkg.sv
package bitslip_aligner_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_SEARCH,
    ST_SETTLE,
    ST_CONFIRM,
    ST_LOCKED
  } alignState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic slip;     // hold the bit counter for one cycle
    logic present;  // forward completed words to the output
  } alignCtrl_t;

endpackage

// File: rtl/aligner_datapath.sv
module aligner_datapath
  import bitslip_aligner_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serIn,
  input  alignCtrl_t        ctrl,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordTick,
  output logic              wordIsTrain,
  output logic              wordValid
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] wordReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              tickQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      wordReg  <= '0;
      bitCnt   <= '0;
      tickQ    <= 1'b0;
    end else begin
      shiftReg <= {shiftReg[WORD_W-2:0], serIn};
      tickQ    <= 1'b0;
      if (ctrl.slip) begin
        bitCnt <= bitCnt;  // boundary moves one bit later
      end else if (bitCnt == LAST_BIT) begin
        bitCnt  <= '0;
        wordReg <= {shiftReg[WORD_W-2:0], serIn};
        tickQ   <= 1'b1;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign wordOut     = wordReg;
  assign wordTick    = tickQ;
  assign wordIsTrain = (wordReg == TRAIN_WORD);
  assign wordValid   = tickQ & ctrl.present;

endmodule

// File: rtl/aligner_ctrl.sv
module aligner_ctrl
  import bitslip_aligner_pkg::*;
#(
  parameter int WORD_W       = 8,
  parameter int SETTLE_WORDS = 2,
  parameter int LOCK_WORDS   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wordTick,
  input  logic                      wordIsTrain,
  output alignCtrl_t                ctrl,
  output logic                      linkUp,
  output logic [$clog2(WORD_W)-1:0] slipCount,
  output logic                      rotated
);
  localparam int SLIP_W   = $clog2(WORD_W);
  localparam int SET_W    = $clog2(SETTLE_WORDS + 1);
  localparam int MATCH_W  = $clog2(LOCK_WORDS + 1);
  localparam logic [SLIP_W-1:0]  SLIP_LAST   = SLIP_W'(WORD_W - 1);
  localparam logic [SET_W-1:0]   SETTLE_LAST = SET_W'(SETTLE_WORDS - 1);
  localparam logic [MATCH_W-1:0] MATCH_LAST  = MATCH_W'(LOCK_WORDS - 1);

  alignState_t        state, stateNext;
  logic [SET_W-1:0]   settleCnt, settleNext;
  logic [MATCH_W-1:0] matchCnt, matchNext;
  logic [SLIP_W-1:0]  slipCnt, slipNext;
  logic               rotQ, rotNext;
  logic               doSlip;

  always_comb begin
    stateNext  = state;
    settleNext = settleCnt;
    matchNext  = matchCnt;
    doSlip     = 1'b0;
    unique case (state)
      ST_RESET: stateNext = ST_SEARCH;
      ST_SEARCH: begin
        if (wordTick) begin
          if (wordIsTrain) begin
            matchNext = MATCH_W'(1);
            stateNext = (LOCK_WORDS == 1) ? ST_LOCKED : ST_CONFIRM;
          end else begin
            doSlip = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        if (wordTick) begin
          if (settleCnt == SETTLE_LAST) begin
            settleNext = '0;
            stateNext  = ST_SEARCH;
          end else begin
            settleNext = settleCnt + 1'b1;
          end
        end
      end
      ST_CONFIRM: begin
        if (wordTick) begin
          if (!wordIsTrain) begin
            doSlip = 1'b1;
          end else if (matchCnt == MATCH_LAST) begin
            stateNext = ST_LOCKED;
          end else begin
            matchNext = matchCnt + 1'b1;
          end
        end
      end
      ST_LOCKED: stateNext = ST_LOCKED;
      default:   stateNext = ST_SEARCH;
    endcase
    if (doSlip) begin
      stateNext  = ST_SETTLE;
      settleNext = '0;
      matchNext  = '0;
    end
  end

  always_comb begin
    slipNext = slipCnt;
    rotNext  = rotQ;
    if (doSlip) begin
      if (slipCnt == SLIP_LAST) begin
        slipNext = '0;
        rotNext  = 1'b1;
      end else begin
        slipNext = slipCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RESET;
      settleCnt <= '0;
      matchCnt  <= '0;
      slipCnt   <= '0;
      rotQ      <= 1'b0;
    end else begin
      state     <= stateNext;
      settleCnt <= settleNext;
      matchCnt  <= matchNext;
      slipCnt   <= slipNext;
      rotQ      <= rotNext;
    end
  end

  assign ctrl.slip    = doSlip;
  assign ctrl.present = (state == ST_LOCKED);
  assign linkUp       = (state == ST_LOCKED);
  assign slipCount    = slipCnt;
  assign rotated      = rotQ;

endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bitslip_aligner_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hF0,
  parameter int SETTLE_WORDS = 2,
  parameter int LOCK_WORDS   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      serIn,
  output logic [WORD_W-1:0]         wordOut,
  output logic                      wordValid,
  output logic                      linkUp,
  output logic [$clog2(WORD_W)-1:0] slipCount,
  output logic                      rotated
);
  alignCtrl_t ctrl;
  logic       wordTick;
  logic       wordIsTrain;

  aligner_datapath #(
    .WORD_W    (WORD_W),
    .TRAIN_WORD(TRAIN_WORD)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .serIn      (serIn),
    .ctrl       (ctrl),
    .wordOut    (wordOut),
    .wordTick   (wordTick),
    .wordIsTrain(wordIsTrain),
    .wordValid  (wordValid)
  );

  aligner_ctrl #(
    .WORD_W      (WORD_W),
    .SETTLE_WORDS(SETTLE_WORDS),
    .LOCK_WORDS  (LOCK_WORDS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wordTick   (wordTick),
    .wordIsTrain(wordIsTrain),
    .ctrl       (ctrl),
    .linkUp     (linkUp),
    .slipCount  (slipCount),
    .rotated    (rotated)
  );

endmodule

// File: rtl/bitslip_aligner_checker.sv
module bitslip_aligner_checker #(
  parameter int WORD_W = 8,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'hF0,
  parameter int SETTLE_WORDS = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic [WORD_W-1:0]         wordOut,
  input logic                      wordValid,
  input logic                      linkUp,
  input logic [$clog2(WORD_W)-1:0] slipCount,
  input logic                      rotated
);
  localparam int GAP_MIN = (SETTLE_WORDS + 1) * WORD_W;

  logic [$clog2(WORD_W)-1:0] prevSlip;
  logic [15:0]               sinceSlip;
  logic                      seenSlip;
  logic                      slipChanged;

  assign slipChanged = (slipCount != prevSlip);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSlip  <= '0;
      sinceSlip <= '0;
      seenSlip  <= 1'b0;
    end else begin
      prevSlip <= slipCount;
      if (slipChanged) begin
        sinceSlip <= 16'd1;
        seenSlip  <= 1'b1;
      end else if (sinceSlip != 16'hFFFF) begin
        sinceSlip <= sinceSlip + 16'd1;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (slipCount == '0 && !linkUp && !rotated && !wordValid)); // R1

  AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
    slipChanged |-> (slipCount == prevSlip + 1'b1)); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
    (slipChanged && seenSlip) |-> (sinceSlip >= 16'(GAP_MIN))); // R3

  AST_LOCK_ON_TRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(linkUp) |-> (wordOut == TRAIN_WORD)); // R4

  AST_LINK_STICKY: assert property (@(posedge clk) disable iff (rst)
    linkUp |=> linkUp); // R5

  AST_ROTATE_STICKY: assert property (@(posedge clk) disable iff (rst)
    rotated |=> rotated); // R6

  AST_FROZEN_SLIP: assert property (@(posedge clk) disable iff (rst)
    linkUp |=> $stable(slipCount)); // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid); // R7

  AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> linkUp); // R7

endmodule

bind bitslip_aligner bitslip_aligner_checker #(
  .WORD_W      (WORD_W),
  .TRAIN_WORD  (TRAIN_WORD),
  .SETTLE_WORDS(SETTLE_WORDS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wordOut  (wordOut),
  .wordValid(wordValid),
  .linkUp   (linkUp),
  .slipCount(slipCount),
  .rotated  (rotated)
);

// File: tb/bitslip_aligner_tb.sv
`timescale 1ns/1ps
module bitslip_aligner_tb;
  localparam logic [7:0] TRAIN = 8'hF0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serIn = 1'b0;
  logic [7:0] wordOut;
  logic       wordValid;
  logic       linkUp;
  logic [2:0] slipCount;
  logic       rotated;

  bitslip_aligner u_dut (
    .clk      (clk),
    .rst      (rst),
    .serIn    (serIn),
    .wordOut  (wordOut),
    .wordValid(wordValid),
    .linkUp   (linkUp),
    .slipCount(slipCount),
    .rotated  (rotated)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // stimulus generator state (owned by the generator block)
  bit         holdRst = 1'b1;
  bit         startReq = 1'b0;
  bit         genOn = 1'b0;
  int         startPhase = 0;
  int         genIdx = 0;
  bit         infTrain = 1'b0;
  int         trainLeft = 0;
  bit         dataMode = 1'b0;
  int         dataIdx = 0;
  logic [7:0] curWord = 8'h00;
  bit         curIsTrain = 1'b0;
  logic [7:0] expQ[$];

  function automatic logic [7:0] dataByte(input int i);
    return 8'(i * 53 + 7);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // driver: serial bits and reset, changed on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (holdRst) begin
      rst   <= 1'b1;
      genOn = 1'b0;
    end else if (startReq) begin
      startReq   = 1'b0;
      rst        <= 1'b0;
      genOn      = 1'b1;
      genIdx     = startPhase;
      curWord    = TRAIN;
      curIsTrain = 1'b1;
    end
    if (genOn) begin
      if (genIdx == 0) begin
        if (trainLeft > 0 || (infTrain && !dataMode)) begin
          curWord    = TRAIN;
          curIsTrain = 1'b1;
          if (trainLeft > 0) trainLeft--;
        end else if (dataMode) begin
          curWord    = dataByte(dataIdx);
          curIsTrain = 1'b0;
          dataIdx++;
        end else begin
          curWord    = 8'h00;
          curIsTrain = 1'b0;
        end
      end
      serIn <= curWord[7 - genIdx];
      if (genIdx == 7 && !curIsTrain) expQ.push_back(curWord);
      genIdx = (genIdx + 1) % 8;
    end
  end

  // monitor: compares every strobed word with the scoreboard
  always @(negedge clk) begin
    if (!rst && wordValid) begin
      logic [7:0] expWord;
      expWord = (expQ.size() == 0) ? TRAIN : expQ.pop_front();
      check("R7 word content", wordOut == expWord, wordOut, expWord);
      check("R7 valid only when locked", linkUp == 1'b1, linkUp, 1);
    end
  end

  // watchdog
  initial begin
    #(5ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic resetAndStart(input int phase, input bit inf, input int left);
    @(posedge clk);
    holdRst = 1'b1;
    waitCycles(4);
    expQ.delete();
    // R1: reset state
    check("R1 linkUp", linkUp == 1'b0, linkUp, 0);
    check("R1 slipCount", slipCount == 3'd0, slipCount, 0);
    check("R1 rotated", rotated == 1'b0, rotated, 0);
    check("R1 wordValid", wordValid == 1'b0, wordValid, 0);
    @(posedge clk);
    startPhase = phase;
    infTrain   = inf;
    trainLeft  = left;
    dataMode   = 1'b0;
    dataIdx    = 0;
    holdRst    = 1'b0;
    startReq   = 1'b1;
  endtask

  initial begin
    waitCycles(3);

    // R2, R5, R7: lock from every bit offset, then carry data
    for (int p = 0; p < 8; p++) begin
      int expSlip;
      expSlip = (8 - p) % 8;
      resetAndStart(p, 1'b1, 0);
      waitCycles(400);
      check("R5 link up", linkUp == 1'b1, linkUp, 1);
      check("R2 slip count at lock", slipCount == 3'(expSlip), slipCount, expSlip);
      check("R6 no rotation", rotated == 1'b0, rotated, 0);
      @(posedge clk);
      dataMode = 1'b1;
      waitCycles(150);
      check("R7 data drained", expQ.size() <= 1, expQ.size(), 0);
      check("R7 slip frozen", slipCount == 3'(expSlip), slipCount, expSlip);
      check("R5 link held", linkUp == 1'b1, linkUp, 1);
    end

    // R3, R6: stream that never matches
    begin
      int lastChange;
      int changes;
      logic [2:0] prev;
      resetAndStart(0, 1'b0, 0);
      lastChange = -1;
      changes = 0;
      prev = 3'd0;
      for (int c = 0; c < 400 && changes < 8; c++) begin
        @(negedge clk);
        if (slipCount != prev) begin
          changes++;
          if (lastChange >= 0)
            check("R3 slip spacing", (c - lastChange) == 25, c - lastChange, 25);
          if (changes == 7)
            check("R6 rotated before wrap", rotated == 1'b0, rotated, 0);
          lastChange = c;
          prev = slipCount;
        end
      end
      check("R6 eight slips seen", changes == 8, changes, 8);
      check("R6 count wrapped", slipCount == 3'd0, slipCount, 0);
      check("R6 rotated set", rotated == 1'b1, rotated, 1);
      check("R4 no lock on zeros", linkUp == 1'b0, linkUp, 0);
      waitCycles(100);
      check("R6 rotated sticky", rotated == 1'b1, rotated, 1);
    end

    // R4: three matches then mismatch must not lock
    resetAndStart(0, 1'b0, 3);
    waitCycles(45);
    check("R4 three matches slip", slipCount == 3'd1, slipCount, 1);
    check("R4 three matches no lock", linkUp == 1'b0, linkUp, 0);

    // R4: four matches lock, later zeros are passed through
    resetAndStart(0, 1'b0, 4);
    waitCycles(45);
    check("R4 four matches lock", linkUp == 1'b1, linkUp, 1);
    check("R4 four matches no slip", slipCount == 3'd0, slipCount, 0);
    waitCycles(80);
    check("R7 zeros drained", expQ.size() <= 1, expQ.size(), 0);

    // R1: reset while locked drops the link
    resetAndStart(0, 1'b1, 0);
    waitCycles(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule